// File: doc/BRIEF.md
# Raster Frame Timing and Vertical-Blank Interrupt Generator

This block keeps the raster position of a tile-based video processor and, from that position alone, produces the frame-level status flags and the interrupt request to the CPU. It runs on the dot clock. A dot counter and a scanline counter sweep the frame. From their values the block sets and clears a vertical-blank flag at exact dots and sets a sprite-zero-hit flag when a precomputed hit position is reached. It emits a one-cycle non-maskable-interrupt pulse when vertical blank begins with interrupts enabled, or when software enables interrupts while vertical blank is already flagged.

The CPU side reaches the block through plain strobes that are already synchronous to the dot clock. One CPU clock spans three dots, so a strobe lasts one dot cycle. `ctrl_wr_i` carries a write of the interrupt-enable control bit on `ctrl_nmi_en_i`. `stat_rd_i` marks a status-register read. The block carries no data stream, so it has no valid/ready handshake, and every pin is a level or a one-cycle strobe. The sprite-hit position comes precomputed on `hit_line_i`/`hit_dot_i`. Pixel generation and the hit computation lie outside the block.

Positions below are written (line, dot). A position "shows" when `line_o`/`dot_o` present it after a clock edge. Parameters: `DOTS` (341 by default), `LINES` (262), `VBL_LINE` (241). The pre-render line is `LINES-1`.

Top module: `frame_timing_gen`

## Requirements
- R1: After reset the position shows (0,0) and `vblank_o`, `hit_o` and `nmi_o` are 0. Each clock advances the dot. After dot `DOTS-1` the dot returns to 0 and the line advances. After line `LINES-1` the line returns to 0.
- R2: `vblank_o` becomes 1 on the same edge at which (`VBL_LINE`,1) shows, not at dot 0. A status read in the cycle that shows (`VBL_LINE`,0) does not prevent the set.
- R3: `vblank_o` is cleared on the edge at which (`LINES-1`,0) shows, which is the end of dot `DOTS-1` of line `LINES-2`. It is never 1 at any position outside (`VBL_LINE`,1) through (`LINES-2`,`DOTS-1`).
- R4: A cycle with `stat_rd_i`=1 still shows the flags unchanged. Apart from the R2 set, `vblank_o` is 0 from the next cycle on.
- R5: On the edge that sets `vblank_o`, `nmi_o` becomes 1 if the interrupt enable is 1. The enable taken here is the bit written in that cycle if `ctrl_wr_i`=1, and the stored bit otherwise.
- R6: A write with `ctrl_nmi_en_i`=1 while the stored enable is 0 and `vblank_o` shows 1 makes `nmi_o` 1 in the next cycle. A write while the enable is already 1, or while `vblank_o` is 0, raises nothing.
- R7: `nmi_o` is a single-cycle pulse, with exactly one pulse per qualifying event of R5 or R6.
- R8: `hit_o` becomes 1 in the cycle after a position (L,D) shows with L=`hit_line_i`, D>=`hit_dot_i`, and `bg_en_i` or `spr_en_i` at 1 in that cycle. Without either enable it does not set.
- R9: `hit_o` stays 1 until the edge that shows (`LINES-1`,0), where it clears together with `vblank_o`. This clear wins over a set. A status read does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Strobe: control-register write this cycle |
| ctrl_nmi_en_i | input | 1 | Interrupt-enable bit carried by the write |
| stat_rd_i | input | 1 | Strobe: status-register read this cycle |
| bg_en_i | input | 1 | Background rendering enabled |
| spr_en_i | input | 1 | Sprite rendering enabled |
| hit_line_i | input | $clog2(LINES) | Scanline of the sprite-zero hit |
| hit_dot_i | input | $clog2(DOTS) | Dot of the sprite-zero hit |
| dot_o | output | $clog2(DOTS) | Current dot |
| line_o | output | $clog2(LINES) | Current scanline |
| vblank_o | output | 1 | Vertical-blank status flag |
| hit_o | output | 1 | Sprite-zero-hit status flag |
| nmi_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench aims at the edges of vertical blank. A design that sets the flag at dot 0 or at a line boundary shows `vblank_o` one cycle early. A design that clears it one line late leaves it high on the pre-render line. A read in the very cycle before the set would, in a design that gives the read priority, lose the flag and the interrupt. Enable writes go in just before, at, and during vertical blank. A design that fires on the level of the enable, or that fails to fire on a late enable, gives repeated, missing or duplicated `nmi_o` pulses. Hit positions are placed so that the hit is reached with and without rendering enabled and on the last vertical-blank dot, which exposes a hit that ignores the enables or survives the end-of-blank clear.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  // Reason an interrupt pulse is being issued on the coming edge.
  typedef enum logic [1:0] {
    NMI_NONE    = 2'd0,
    NMI_AT_VBL  = 2'd1,
    NMI_LATE_EN = 2'd2
  } nmi_cause_e;
endpackage

// File: rtl/ftg_raster_counter.sv
module ftg_raster_counter #(
  parameter int DOTS  = 341,
  parameter int LINES = 262,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic [DOT_W-1:0]  dot_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q  <= '0;
      line_q <= '0;
    end else if (dot_q == DOT_LAST) begin
      dot_q  <= '0;
      line_q <= (line_q == LINE_LAST) ? '0 : line_q + LINE_W'(1);
    end else begin
      dot_q  <= dot_q + DOT_W'(1);
    end
  end

  assign dot_o  = dot_q;
  assign line_o = line_q;
endmodule

// File: rtl/ftg_status_flags.sv
module ftg_status_flags #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              stat_rd_i,
  input  logic              bg_en_i,
  input  logic              spr_en_i,
  input  logic [LINE_W-1:0] hit_line_i,
  input  logic [DOT_W-1:0]  hit_dot_i,
  output logic              vbl_set_evt_o,
  output logic              vblank_o,
  output logic              hit_o
);
  localparam logic [LINE_W-1:0] VBL_L    = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] LAST_VBL = LINE_W'(LINES - 2);
  localparam logic [DOT_W-1:0]  DOT_LAST = DOT_W'(DOTS - 1);

  logic set_evt, clr_evt, hit_reached;
  logic vbl_q, hit_q;

  // Decisions are taken on the position shown now, so the new flag value
  // appears together with the next position.
  assign set_evt     = (line_i == VBL_L) && (dot_i == '0);
  assign clr_evt     = (line_i == LAST_VBL) && (dot_i == DOT_LAST);
  assign hit_reached = (line_i == hit_line_i) && (dot_i >= hit_dot_i) &&
                       (bg_en_i || spr_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbl_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      // Set beats read; end-of-blank clear beats read.
      if (set_evt)        vbl_q <= 1'b1;
      else if (clr_evt)   vbl_q <= 1'b0;
      else if (stat_rd_i) vbl_q <= 1'b0;

      if (clr_evt)          hit_q <= 1'b0;
      else if (hit_reached) hit_q <= 1'b1;
    end
  end

  assign vbl_set_evt_o = set_evt;
  assign vblank_o      = vbl_q;
  assign hit_o         = hit_q;
endmodule

// File: rtl/ftg_nmi_gen.sv
module ftg_nmi_gen
  import ftg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vbl_set_evt_i,
  input  logic vblank_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_nmi_en_i,
  output logic nmi_o
);
  logic       en_q, en_eff, late_en;
  logic       nmi_q;
  nmi_cause_e cause;

  assign en_eff  = ctrl_wr_i ? ctrl_nmi_en_i : en_q;
  assign late_en = ctrl_wr_i && ctrl_nmi_en_i && !en_q && vblank_i;

  always_comb begin
    if (vbl_set_evt_i && en_eff) cause = NMI_AT_VBL;
    else if (late_en)            cause = NMI_LATE_EN;
    else                         cause = NMI_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      en_q  <= en_eff;
      nmi_q <= (cause != NMI_NONE);
    end
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_nmi_en_i,
  input  logic              stat_rd_i,
  input  logic              bg_en_i,
  input  logic              spr_en_i,
  input  logic [LINE_W-1:0] hit_line_i,
  input  logic [DOT_W-1:0]  hit_dot_i,
  output logic [DOT_W-1:0]  dot_o,
  output logic [LINE_W-1:0] line_o,
  output logic              vblank_o,
  output logic              hit_o,
  output logic              nmi_o
);
  logic vbl_set_evt;

  ftg_raster_counter #(.DOTS(DOTS), .LINES(LINES)) u_raster (
    .clk    (clk),
    .rst_n  (rst_n),
    .dot_o  (dot_o),
    .line_o (line_o)
  );

  ftg_status_flags #(.DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .dot_i         (dot_o),
    .line_i        (line_o),
    .stat_rd_i     (stat_rd_i),
    .bg_en_i       (bg_en_i),
    .spr_en_i      (spr_en_i),
    .hit_line_i    (hit_line_i),
    .hit_dot_i     (hit_dot_i),
    .vbl_set_evt_o (vbl_set_evt),
    .vblank_o      (vblank_o),
    .hit_o         (hit_o)
  );

  ftg_nmi_gen u_nmi (
    .clk           (clk),
    .rst_n         (rst_n),
    .vbl_set_evt_i (vbl_set_evt),
    .vblank_i      (vblank_o),
    .ctrl_wr_i     (ctrl_wr_i),
    .ctrl_nmi_en_i (ctrl_nmi_en_i),
    .nmi_o         (nmi_o)
  );
endmodule

// File: rtl/frame_timing_gen_sva.sv
module frame_timing_gen_sva #(
  parameter int DOTS     = 341,
  parameter int LINES    = 262,
  parameter int VBL_LINE = 241,
  localparam int DOT_W  = $clog2(DOTS),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr_i,
  input logic              ctrl_nmi_en_i,
  input logic              stat_rd_i,
  input logic              bg_en_i,
  input logic              spr_en_i,
  input logic [LINE_W-1:0] line_o,
  input logic [DOT_W-1:0]  dot_o,
  input logic              vblank_o,
  input logic              hit_o,
  input logic              nmi_o
);
  localparam logic [LINE_W-1:0] VBL_L    = LINE_W'(VBL_LINE);
  localparam logic [LINE_W-1:0] PRE_L    = LINE_W'(LINES - 1);
  localparam logic [LINE_W-1:0] LAST_VBL = LINE_W'(LINES - 2);
  localparam logic [DOT_W-1:0]  DOT_LAST = DOT_W'(DOTS - 1);

  logic in_window;
  assign in_window = (line_o >= VBL_L) && (line_o < PRE_L) &&
                     !((line_o == VBL_L) && (dot_o == '0));

  p_pos_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dot_o) < DOTS) && (32'(line_o) < LINES));

  p_vbl_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_o == VBL_L) && (dot_o == DOT_W'(1))) |-> vblank_o);

  p_vbl_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> in_window);

  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && vblank_o) |=> !vblank_o);

  p_nmi_at_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_o == VBL_L) && (dot_o == '0) && ctrl_wr_i && ctrl_nmi_en_i) |=> nmi_o);

  p_nmi_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o);

  p_hit_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> $past(bg_en_i || spr_en_i));

  p_hit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !((line_o == LAST_VBL) && (dot_o == DOT_LAST))) |=> hit_o);

  p_pre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_o == PRE_L) && (dot_o == '0)) |-> (!vblank_o && !hit_o));
endmodule

bind frame_timing_gen frame_timing_gen_sva #(
  .DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL_LINE)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_wr_i     (ctrl_wr_i),
  .ctrl_nmi_en_i (ctrl_nmi_en_i),
  .stat_rd_i     (stat_rd_i),
  .bg_en_i       (bg_en_i),
  .spr_en_i      (spr_en_i),
  .line_o        (line_o),
  .dot_o         (dot_o),
  .vblank_o      (vblank_o),
  .hit_o         (hit_o),
  .nmi_o         (nmi_o)
);

// File: tb/frame_timing_gen_bench.sv
module frame_timing_gen_bench;
  localparam int DOTS = 20, LINES = 12, VBL = 8;
  localparam int DW = $clog2(DOTS), LW = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, wd = 0, rd = 0, bg = 0, spr = 0;
  logic [LW-1:0] hl = '0;
  logic [DW-1:0] hd = '0;
  logic [DW-1:0] dot;
  logic [LW-1:0] line;
  logic vbl, hit, nmi;

  always #2 clk = ~clk;

  frame_timing_gen #(.DOTS(DOTS), .LINES(LINES), .VBL_LINE(VBL)) u_frame_timing_gen (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(wr), .ctrl_nmi_en_i(wd), .stat_rd_i(rd),
    .bg_en_i(bg), .spr_en_i(spr), .hit_line_i(hl), .hit_dot_i(hd),
    .dot_o(dot), .line_o(line), .vblank_o(vbl), .hit_o(hit), .nmi_o(nmi));

  int total = 0, bad = 0;
  int m_dot = 0, m_line = 0, seed = 0;
  bit m_vbl = 0, m_hit = 0, m_en = 0, m_nmi = 0;
  string t_vbl = "R1", t_hit = "R1", t_nmi = "R1";

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at line %0d dot %0d: actual=%0d expected=%0d", req, m_line, m_dot, act, exp);
    end
  endtask

  function automatic int next_dot(int d);
    return (d == DOTS - 1) ? 0 : d + 1;
  endfunction
  function automatic int next_line(int l, int d);
    if (d != DOTS - 1) return l;
    return (l == LINES - 1) ? 0 : l + 1;
  endfunction

  // Reference step from the requirements; uses current inputs and state.
  task automatic model_step();
    bit set_e, clr_e, en_eff, reach;
    set_e  = (m_line == VBL) && (m_dot == 0);
    clr_e  = (m_line == LINES - 2) && (m_dot == DOTS - 1);
    en_eff = wr ? wd : m_en;
    reach  = (m_line == int'(hl)) && (m_dot >= int'(hd)) && (bg || spr);
    t_nmi = "R7";
    m_nmi = 0;
    if (set_e && en_eff) begin m_nmi = 1; t_nmi = "R5"; end
    else if (wr && wd && !m_en && m_vbl) begin m_nmi = 1; t_nmi = "R6"; end
    m_en = en_eff;
    t_vbl = "R2";
    if (set_e) m_vbl = 1;
    else if (clr_e) begin m_vbl = 0; t_vbl = "R3"; end
    else if (rd) begin if (m_vbl) t_vbl = "R4"; m_vbl = 0; end
    t_hit = "R9";
    if (clr_e) m_hit = 0;
    else if (reach) begin if (!m_hit) t_hit = "R8"; m_hit = 1; end
    m_line = next_line(m_line, m_dot);
    m_dot  = next_dot(m_dot);
  endtask

  task automatic compare();
    chk("R1", int'(dot), m_dot);
    chk("R1", int'(line), m_line);
    chk(t_vbl, int'(vbl), int'(m_vbl));
    chk(t_hit, int'(hit), int'(m_hit));
    chk(t_nmi, int'(nmi), int'(m_nmi));
  endtask

  // One cycle: inputs already driven; step model, advance clock, compare.
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare();
    wr = 0; rd = 0;
  endtask

  task automatic run_to(int l, int d);
    while (!(m_line == l && m_dot == d)) cycle();
  endtask

  task automatic run_random(int n, int p_rd, int p_wr);
    for (int i = 0; i < n; i++) begin
      rd = (($urandom % 100) < p_rd);
      wr = (($urandom % 100) < p_wr);
      wd = $urandom % 2;
      if (($urandom % 50) == 0) begin bg = $urandom % 2; spr = $urandom % 2; end
      if (m_line == 0 && m_dot == 0) begin
        hl = LW'($urandom % LINES);
        hd = DW'($urandom % DOTS);
      end
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(dot), 0); chk("R1", int'(line), 0);
    chk("R1", int'(vbl), 0); chk("R1", int'(hit), 0); chk("R1", int'(nmi), 0);
    rst_n = 1'b1;
    // R2/R5: enable on, read in the cycle before the set must not suppress it
    wr = 1; wd = 1; cycle();
    run_to(VBL, 0);
    rd = 1; cycle();
    chk("R2", int'(vbl), 1); chk("R5", int'(nmi), 1);
    cycle(); chk("R7", int'(nmi), 0);
    // R4: read returns 1, then clears
    chk("R4", int'(vbl), 1); rd = 1; cycle(); chk("R4", int'(vbl), 0);
    // R6: disable, then enable during blank with flag cleared -> no pulse
    wr = 1; wd = 0; cycle();
    wr = 1; wd = 1; cycle(); cycle(); chk("R6", int'(nmi), 0);
    // next frame: enable off at set, enable late -> one pulse, rewrite -> none
    wr = 1; wd = 0; cycle();
    run_to(VBL, 3);
    chk("R5", int'(nmi), 0);
    wr = 1; wd = 1; cycle(); chk("R6", int'(nmi), 1);
    wr = 1; wd = 1; cycle(); chk("R6", int'(nmi), 0);
    // R8: hit without enables does not set; with enable it does; R9 read keeps it
    bg = 0; spr = 0; hl = LW'(LINES - 2); hd = DW'(DOTS - 1);
    run_to(LINES - 2, DOTS - 1);
    chk("R8", int'(hit), 0);
    hl = LW'(2); hd = DW'(5); spr = 1;
    run_to(2, 6); chk("R8", int'(hit), 1);
    rd = 1; cycle(); chk("R9", int'(hit), 1);
    // R9: hit on the last blank dot loses to the clear
    bg = 1; spr = 0; hl = LW'(LINES - 2); hd = DW'(DOTS - 1);
    run_to(LINES - 1, 0); chk("R9", int'(hit), 0); chk("R3", int'(vbl), 0);
    // mixed random traffic
    run_random(3000, 8, 10);
    run_random(3000, 1, 25);
    run_random(2000, 30, 5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule